// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer with Byte-Wide Host Bus

This block is the digital half of a 10-bit successive-approximation converter that talks to a host over an 8-bit parallel bus. The host writes a configuration byte with a write strobe while chip select is low. That byte selects the input channel, single-ended or pseudo-differential input, unipolar or bipolar coding, the acquisition style and the clock or power mode. The block then runs the track phase and the hold instant. After that it runs a 13-tick bit-by-bit search. In each tick it drives a trial code to the DAC and reads back one comparator bit.

When the result is ready an active-low flag falls. The host reads the 10-bit result as two bytes, chosen by a byte-select pin. All host pins, the comparator bit and the two conversion clocks are asynchronous to the system clock. The two conversion clocks are an external pin clock and a stand-in for the on-chip oscillator. The block synchronizes all of these inputs and edge-detects them. The data bus is driven through an explicit output enable.

Top module: `sar_ctrl`

## Requirements
- R1: After reset, done_n is 1, dout_oe is 0, track is 0, pwr_stby and pwr_off are 0, and the external conversion clock is selected.
- R2: Configuration byte bits [7:6] select the mode. 11 gives normal operation on ext_ck and 10 gives normal operation on osc_ck. 01 requests standby and 00 requests full power-down; both keep the last selected conversion clock. Conversion ticks are falling edges of the selected clock.
- R3: A write with bit 5 = 0 raises track on its rising edge. Track falls (hold) on the 4th falling conversion-clock edge after the write, so the block acquires for 3 clocks.
- R4: A write with bit 5 = 1 holds track high for an unbounded time. A following write with bit 5 = 0 and the same channel bits [2:0] starts the conversion at once, with no counted acquisition. If the channel bits differ, that write starts a normal counted acquisition instead.
- R5: The conversion lasts 13 falling conversion-clock edges after the hold edge. done_n falls after the 13th.
- R6: dac_code tries bits from MSB to LSB. Each trial bit is kept when cmp = 1 (input at or above the trial code). In unipolar mode (bit 3 = 1) the result equals the largest code not above the input, in straight binary.
- R7: In bipolar mode (bit 3 = 0) the stored result is the search code with bit 9 inverted, which is two's complement.
- R8: done_n returns to 1 on the falling edge of rd_n with chip select low. It also returns to 1 on any accepted write.
- R9: A write accepted during a conversion abandons it without lowering done_n and starts the new acquisition. The earlier result is not replaced by the abandoned one.
- R10: While cs_n is 1, wr_n and rd_n have no effect, ext_ck ticks are ignored and dout_oe is 0.
- R11: While reading, byte_hi = 0 puts result[7:0] on dout. byte_hi = 1 puts result[9:8] on dout[1:0], with dout[7:2] equal to 0 in unipolar mode and to result[9] in bipolar mode.
- R12: A standby or power-down request takes effect only when the conversion it started completes. The next accepted write clears it.
- R13: mux_sel follows channel bits [2:0] and mux_se follows bit 4 (1 = single-ended) of the last accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe; byte accepted on rising edge |
| rd_n | input | 1 | Read strobe, active low |
| byte_hi | input | 1 | Selects high result byte on the bus |
| ext_ck | input | 1 | External conversion clock |
| osc_ck | input | 1 | Oscillator conversion clock |
| din | input | 8 | Configuration byte from host |
| cmp | input | 1 | Comparator decision for current trial code |
| dout | output | 8 | Result byte toward host |
| dout_oe | output | 1 | Bus drive enable |
| done_n | output | 1 | Result-ready flag, active low |
| dac_code | output | 10 | Trial code for the capacitive DAC |
| track | output | 1 | Track/hold control, 1 = tracking |
| mux_sel | output | 3 | Input channel select |
| mux_se | output | 1 | 1 = single-ended input pairing |
| pwr_stby | output | 1 | Standby request to analog section |
| pwr_off | output | 1 | Full power-down request |

## Verification
The bench counts falling edges of the selected conversion clock between each write and the result flag. A hold taken one edge early or late, or a search of the wrong length, therefore shows up directly in the counts. It sweeps input codes across both polarities, including both rails and the mid-scale neighbours. These show a wrong keep/clear decision, a missed MSB inversion or a high byte that is not sign-extended.

It also covers the two-write acquisition with matching and with changed channel bits, and an abort in the middle of a search. A design that let the abandoned search finish would post the wrong value. A design that treated a changed channel as a go signal would skip the counted track phase. Power-down codes are run under the oscillator clock. A design that switched clocks or powered down too early would show a wrong edge count, or the power flags would appear before the result.

// File: rtl/sar_ctrl_pkg.sv
package sar_ctrl_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ACQ,
    ST_OPEN,
    ST_CONV
  } sar_state_e;

  // Host configuration byte; field order is fixed by the host software contract
  typedef struct packed {
    logic [1:0] pwr;       // 11 ext clock, 10 osc clock, 01 standby, 00 off
    logic       acq_host;  // 1: host ends acquisition with a second write
    logic       single;    // 1: single-ended
    logic       unipolar;  // 1: straight binary, 0: two's complement
    logic [2:0] chan;
  } ctl_byte_t;

  localparam int BYTE_W = $bits(ctl_byte_t);

endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sar_engine.sv
module sar_engine #(
  parameter int RES_W      = 10,
  parameter int CONV_TICKS = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic             cmp,
  output logic [RES_W-1:0] code,
  output logic             finish
);
  localparam int CNT_W = $clog2(CONV_TICKS);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] probe;
  logic [CNT_W-1:0] cnt;
  logic             busy;

  assign finish = busy & tick & (cnt == CNT_W'(CONV_TICKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      code  <= '0;
      probe <= '0;
      cnt   <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      code  <= TOP_BIT;
      probe <= TOP_BIT;
      cnt   <= '0;
      busy  <= 1'b1;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (busy && tick) begin
      code  <= (cmp ? code : (code & ~probe)) | (probe >> 1);
      probe <= probe >> 1;
      cnt   <= cnt + 1'b1;
      if (finish) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_bus.sv
module sar_bus #(
  parameter int RES_W = 10,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             hi_sel,
  input  logic             bip,
  input  logic [RES_W-1:0] result,
  output logic [BUS_W-1:0] dout,
  output logic             oe
);
  localparam int HI_W  = RES_W - BUS_W;
  localparam int PAD_W = BUS_W - HI_W;

  logic [BUS_W-1:0] hi_byte;
  assign hi_byte = {{PAD_W{bip & result[RES_W-1]}}, result[RES_W-1:BUS_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
      oe   <= 1'b0;
    end else begin
      oe   <= en;
      dout <= hi_sel ? hi_byte : result[BUS_W-1:0];
    end
  end
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl
  import sar_ctrl_pkg::*;
#(
  parameter int RES_W       = 10,
  parameter int ACQ_TICKS   = 4,
  parameter int CONV_TICKS  = 13,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              byte_hi,
  input  logic              ext_ck,
  input  logic              osc_ck,
  input  logic [BYTE_W-1:0] din,
  input  logic              cmp,
  output logic [BYTE_W-1:0] dout,
  output logic              dout_oe,
  output logic              done_n,
  output logic [RES_W-1:0]  dac_code,
  output logic              track,
  output logic [2:0]        mux_sel,
  output logic              mux_se,
  output logic              pwr_stby,
  output logic              pwr_off
);
  localparam int NCTL  = 7;
  localparam int ACQ_W = $clog2(ACQ_TICKS);
  localparam logic [NCTL-1:0]  CTL_RST = 7'b1110000;
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  // synchronized pins: {cs, wr, rd, hi, ext, osc, cmp}
  logic [NCTL-1:0]   ctl_s;
  logic [BYTE_W-1:0] din_s;
  logic cs_s, wr_s, rd_s, hi_s, ext_s, osc_s, cmp_s;

  sar_sync #(.W(NCTL), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
    .clk(clk), .rst(rst),
    .d({cs_n, wr_n, rd_n, byte_hi, ext_ck, osc_ck, cmp}),
    .q(ctl_s)
  );
  sar_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_din_sync (
    .clk(clk), .rst(rst), .d(din), .q(din_s)
  );
  assign {cs_s, wr_s, rd_s, hi_s, ext_s, osc_s, cmp_s} = ctl_s;

  logic wr_q, rd_q, ext_q, osc_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= 1'b1;
      rd_q  <= 1'b1;
      ext_q <= 1'b0;
      osc_q <= 1'b0;
    end else begin
      wr_q  <= wr_s;
      rd_q  <= rd_s;
      ext_q <= ext_s;
      osc_q <= osc_s;
    end
  end

  logic      cs_act, wr_ev, rd_ev, tick, clk_ext;
  ctl_byte_t wb;
  assign cs_act = ~cs_s;
  assign wr_ev  = cs_act & wr_s & ~wr_q;
  assign rd_ev  = cs_act & ~rd_s & rd_q;
  assign tick   = clk_ext ? (ext_q & ~ext_s & cs_act) : (osc_q & ~osc_s);
  assign wb     = ctl_byte_t'(din_s);

  sar_state_e       st, st_n;
  logic [ACQ_W-1:0] acq_cnt, acq_n;
  logic             eng_start, eng_fin;
  logic [2:0]       cfg_chan;
  logic             cfg_single, cfg_uni;
  logic             pend_stby, pend_off;
  logic [RES_W-1:0] result;
  logic             res_bip;
  logic             conv_busy;

  sar_engine #(.RES_W(RES_W), .CONV_TICKS(CONV_TICKS)) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .abort(wr_ev), .tick(tick),
    .cmp(cmp_s), .code(dac_code), .finish(eng_fin)
  );

  always_comb begin
    st_n      = st;
    acq_n     = acq_cnt;
    eng_start = 1'b0;
    case (st)
      ST_ACQ: if (tick) begin
        if (acq_cnt == ACQ_W'(ACQ_TICKS - 1)) begin
          st_n      = ST_CONV;
          eng_start = 1'b1;
        end else begin
          acq_n = acq_cnt + 1'b1;
        end
      end
      ST_CONV: if (eng_fin) st_n = ST_IDLE;
      default: ;
    endcase
    if (wr_ev) begin
      acq_n     = '0;
      eng_start = 1'b0;
      if (st == ST_OPEN && !wb.acq_host && wb.chan == cfg_chan) begin
        st_n      = ST_CONV;
        eng_start = 1'b1;
      end else if (wb.acq_host) begin
        st_n = ST_OPEN;
      end else begin
        st_n = ST_ACQ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      acq_cnt    <= '0;
      track      <= 1'b0;
      cfg_chan   <= '0;
      cfg_single <= 1'b0;
      cfg_uni    <= 1'b0;
      clk_ext    <= 1'b1;
      pend_stby  <= 1'b0;
      pend_off   <= 1'b0;
      pwr_stby   <= 1'b0;
      pwr_off    <= 1'b0;
      done_n     <= 1'b1;
      result     <= '0;
      res_bip    <= 1'b0;
    end else begin
      st      <= st_n;
      acq_cnt <= acq_n;
      track   <= (st_n == ST_ACQ) || (st_n == ST_OPEN);
      if (wr_ev) begin
        cfg_chan   <= wb.chan;
        cfg_single <= wb.single;
        cfg_uni    <= wb.unipolar;
        done_n     <= 1'b1;
        pwr_stby   <= 1'b0;
        pwr_off    <= 1'b0;
        if (wb.pwr[1]) clk_ext <= wb.pwr[0];
        pend_stby  <= (wb.pwr == 2'b01);
        pend_off   <= (wb.pwr == 2'b00);
      end else begin
        if (rd_ev) done_n <= 1'b1;
        if (st == ST_CONV && eng_fin) begin
          result   <= cfg_uni ? dac_code : (dac_code ^ TOP_BIT);
          res_bip  <= ~cfg_uni;
          done_n   <= 1'b0;
          pwr_stby <= pend_stby;
          pwr_off  <= pend_off;
        end
      end
    end
  end

  sar_bus #(.RES_W(RES_W), .BUS_W(BYTE_W)) u_bus (
    .clk(clk), .rst(rst), .en(cs_act & ~rd_s), .hi_sel(hi_s), .bip(res_bip),
    .result(result), .dout(dout), .oe(dout_oe)
  );

  assign mux_sel   = cfg_chan;
  assign mux_se    = cfg_single;
  assign conv_busy = (st == ST_CONV);
endmodule

// File: rtl/sar_ctrl_chk.sv
module sar_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic dout_oe,
  input logic done_n,
  input logic track,
  input logic conv_busy,
  input logic pwr_stby,
  input logic pwr_off
);
  // R10
  cs_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n, 3) |-> !dout_oe);

  // R8
  flag_clear_acq_chk: assert property (@(posedge clk) disable iff (rst)
    track |-> done_n);

  // R5
  done_from_conv_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(done_n) |-> $past(conv_busy));

  // R3
  hold_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(track && conv_busy));

  // R12
  pd_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (pwr_stby || pwr_off) |-> (!conv_busy && !track));

  // R12
  pd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pwr_stby && pwr_off));
endmodule

bind sar_ctrl sar_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .dout_oe(dout_oe), .done_n(done_n),
  .track(track), .conv_busy(conv_busy), .pwr_stby(pwr_stby), .pwr_off(pwr_off)
);

// File: tb/sar_ctrl_tb_top.sv
module sar_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, byte_hi = 1'b0;
  logic       ext_ck = 1'b0, osc_ck = 1'b0;
  logic [7:0] din = '0;
  logic [9:0] vin = '0;
  logic       cmp;
  logic [7:0] dout;
  logic       dout_oe, done_n, track, mux_se, pwr_stby, pwr_off;
  logic [9:0] dac_code;
  logic [2:0] mux_sel;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;
  always begin repeat (8) @(negedge clk); ext_ck = ~ext_ck; end
  always begin repeat (6) @(negedge clk); osc_ck = ~osc_ck; end
  assign cmp = (vin >= dac_code);

  sar_ctrl dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .byte_hi(byte_hi),
    .ext_ck(ext_ck), .osc_ck(osc_ck), .din(din), .cmp(cmp), .dout(dout),
    .dout_oe(dout_oe), .done_n(done_n), .dac_code(dac_code), .track(track),
    .mux_sel(mux_sel), .mux_se(mux_se), .pwr_stby(pwr_stby), .pwr_off(pwr_off)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] b, input bit osc);
    if (osc) @(negedge osc_ck); else @(negedge ext_ck);
    @(negedge clk);
    din = b; wr_n = 1'b0;
    repeat (3) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic measure(input bit osc, output int acq, output int tot);
    bit run = 1'b1;
    acq = 0; tot = 0;
    while (run) begin
      if (osc) @(negedge osc_ck); else @(negedge ext_ck);
      if (!done_n) run = 1'b0;
      else begin
        tot++;
        if (track) acq++;
      end
    end
  endtask

  task automatic read_check(input logic [9:0] v, input bit bip);
    logic [9:0] r;
    logic [7:0] hi;
    r  = bip ? (v ^ 10'h200) : v;
    hi = {{6{bip & r[9]}}, r[9:8]};
    chk(done_n == 1'b0, "R5 flag low before read", done_n, 0);
    @(negedge clk); byte_hi = 1'b0; rd_n = 1'b0;
    repeat (6) @(negedge clk);
    chk(dout_oe == 1'b1, "R11 bus driven", dout_oe, 1);
    chk(dout == r[7:0], bip ? "R7 low byte" : "R6 low byte", dout, r[7:0]);
    byte_hi = 1'b1;
    repeat (6) @(negedge clk);
    chk(dout == hi, bip ? "R7 high byte sign" : "R11 high byte", dout, hi);
    chk(done_n == 1'b1, "R8 read releases flag", done_n, 1);
    rd_n = 1'b1; byte_hi = 1'b0;
    repeat (6) @(negedge clk);
    chk(dout_oe == 1'b0, "R11 bus released", dout_oe, 0);
  endtask

  task automatic run_conv(input logic [7:0] b, input bit osc, input int exp_acq);
    int acq, tot;
    do_write(b, osc);
    chk(mux_sel == b[2:0], "R13 channel", mux_sel, b[2:0]);
    chk(mux_se == b[4], "R13 pairing", mux_se, b[4]);
    chk(!pwr_stby && !pwr_off, "R12 wake on write", {pwr_stby, pwr_off}, 0);
    measure(osc, acq, tot);
    chk(acq == exp_acq, "R3 acquisition edges", acq, exp_acq);
    chk(tot - acq == 13, "R5 conversion edges", tot - acq, 13);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int acq, tot;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (6) @(negedge clk);
    // R1 reset state
    chk(done_n == 1'b1, "R1 flag", done_n, 1);
    chk(dout_oe == 1'b0, "R1 bus", dout_oe, 0);
    chk(track == 1'b0, "R1 track", track, 0);
    chk(!pwr_stby && !pwr_off, "R1 power", {pwr_stby, pwr_off}, 0);

    // R2 reset selects ext clock; standby request applies after completion (R12)
    vin = 10'd300;
    run_conv(8'b01_0_1_1_101, 1'b0, 4);
    repeat (4) @(negedge clk);
    chk(pwr_stby == 1'b1 && pwr_off == 1'b0, "R12 standby after result", pwr_stby, 1);
    read_check(10'd300, 1'b0);

    // R6 unipolar sweep on ext clock
    for (int k = 0; k < 34; k++) begin
      logic [9:0] v;
      case (k)
        0: v = 10'd0; 1: v = 10'd1023; 2: v = 10'd512; 3: v = 10'd511;
        default: v = 10'((k * 97 + 13) % 1024);
      endcase
      vin = v;
      run_conv({2'b11, 1'b0, k[0], 1'b1, k[2:0]}, 1'b0, 4);
      read_check(v, 1'b0);
    end

    // R7 bipolar sweep
    for (int k = 0; k < 22; k++) begin
      logic [9:0] v;
      case (k)
        0: v = 10'd0; 1: v = 10'd1023; 2: v = 10'd512; 3: v = 10'd511;
        default: v = 10'((k * 61 + 5) % 1024);
      endcase
      vin = v;
      run_conv({2'b11, 1'b0, 1'b1, 1'b0, k[2:0]}, 1'b0, 4);
      read_check(v, 1'b1);
    end

    // R2 oscillator clock, then power codes keep it
    for (int k = 0; k < 4; k++) begin
      vin = 10'(k * 250 + 7);
      run_conv({2'b10, 1'b0, 1'b1, 1'b1, 3'(k)}, 1'b1, 4);
      read_check(10'(k * 250 + 7), 1'b0);
    end
    vin = 10'd444;
    run_conv(8'b01_0_1_1_010, 1'b1, 4);
    repeat (4) @(negedge clk);
    chk(pwr_stby == 1'b1, "R12 standby on osc clock", pwr_stby, 1);
    read_check(10'd444, 1'b0);
    vin = 10'd888;
    run_conv(8'b00_0_1_0_011, 1'b1, 4);
    repeat (4) @(negedge clk);
    chk(pwr_off == 1'b1 && pwr_stby == 1'b0, "R12 full off after result", pwr_off, 1);
    read_check(10'd888, 1'b1);
    vin = 10'd123;
    run_conv(8'b11_0_1_1_001, 1'b0, 4);
    read_check(10'd123, 1'b0);

    // R4 host-timed acquisition
    vin = 10'd777;
    do_write(8'b11_1_1_1_010, 1'b0);
    repeat (200) @(negedge clk);
    chk(track == 1'b1, "R4 open track", track, 1);
    chk(done_n == 1'b1, "R4 no result yet", done_n, 1);
    run_conv(8'b11_0_1_1_010, 1'b0, 0);
    read_check(10'd777, 1'b0);
    // R4 changed channel -> counted acquisition
    vin = 10'd66;
    do_write(8'b11_1_1_1_010, 1'b0);
    repeat (50) @(negedge clk);
    run_conv(8'b11_0_1_1_100, 1'b0, 4);
    read_check(10'd66, 1'b0);

    // R9 abort mid-conversion
    vin = 10'd100;
    do_write(8'b11_0_1_1_000, 1'b0);
    repeat (8) @(negedge ext_ck);
    chk(track == 1'b0 && done_n == 1'b1, "R9 converting", {track, done_n}, 1);
    vin = 10'd900;
    run_conv(8'b11_0_1_1_000, 1'b0, 4);
    read_check(10'd900, 1'b0);

    // R8 write releases flag without read
    vin = 10'd50;
    run_conv(8'b11_0_1_1_110, 1'b0, 4);
    chk(done_n == 1'b0, "R8 flag low", done_n, 0);
    vin = 10'd51;
    do_write(8'b11_0_1_1_110, 1'b0);
    chk(done_n == 1'b1, "R8 write releases flag", done_n, 1);
    measure(1'b0, acq, tot);
    chk(tot == 17, "R5 total edges", tot, 17);
    read_check(10'd51, 1'b0);

    // R10 chip select high stalls ext ticks and ignores strobes
    vin = 10'd640;
    do_write(8'b11_0_1_1_111, 1'b0);
    repeat (6) @(negedge ext_ck);
    @(negedge clk); cs_n = 1'b1;
    repeat (400) @(negedge clk);
    chk(done_n == 1'b1, "R10 ext ticks ignored", done_n, 1);
    din = 8'b11_0_1_1_001; wr_n = 1'b0; rd_n = 1'b0;
    repeat (6) @(negedge clk);
    wr_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(dout_oe == 1'b0, "R10 bus high-z", dout_oe, 0);
    chk(track == 1'b0 && mux_sel == 3'd7, "R10 write ignored", mux_sel, 7);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b0;
    while (done_n) @(negedge clk);
    repeat (3) @(negedge clk);
    cs_n = 1'b1;
    rd_n = 1'b0;
    repeat (6) @(negedge clk);
    rd_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(done_n == 1'b0, "R10 read ignored", done_n, 0);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    read_check(10'd640, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule